// File: doc/BRIEF.md
# Dual-Width Word Serializer

This block turns parallel transmission characters into a continuous serial bit stream. A static width select picks between one 10-bit character per word and two 10-bit characters per word (a 20-bit word). A bit-rate enable, which stands in for the strobe a clock multiplier would supply, advances the block one serial bit at a time. The block keeps its own bit count within each word. From that count it derives a word-rate clock for the upstream logic.

On every rising edge of that word clock, the parallel input is captured into a holding register. At the same edge the word captured one period earlier is loaded into the output shift register. Each word therefore reaches the line one word period after it is captured, and consecutive words follow each other with no gap bits. Two serial outputs carry the same stream: a line output and a loopback output. Each has its own enable, and a disabled output holds a fixed idle level while shifting continues underneath.

The width select is meant to be held static and is changed only while reset is asserted. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `dws_serializer`

## Requirements
- R1: While reset is held, the word clock output is 1 and both serial outputs are 0.
- R2: With `wide_i` = 1 (20-bit mode), each word goes out in ascending index order, `par_i[0]` first and `par_i[19]` last.
- R3: With `wide_i` = 0 (10-bit mode), each word goes out as `par_i[10]` first through `par_i[19]` last. In 8B/10B letters, the order is a, b, c, d, e, i, f, g, h, j.
- R4: In 10-bit mode, `par_i[9:0]` has no effect on either serial output.
- R5: The word present at a rising edge of `wclk_o` is captured at that edge. Its first bit appears at the next rising edge of `wclk_o`, and consecutive words are sent back to back with no gap bits.
- R6: The serial outputs and `wclk_o` change only on clock edges where `bit_en` is 1. Gaps in `bit_en` stretch the timing without dropping or repeating bits.
- R7: `wclk_o` has a period of exactly 20 (20-bit mode) or 10 (10-bit mode) enabled bits. It is 1 for the first half of the period and 0 for the second half.
- R8: When `line_oe` (or `loop_oe`) is 0, the matching serial output holds the idle level (parameter, default 0). The stream keeps its position underneath, so data resumes correctly when the output is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | Bit-rate enable: one serial bit per edge where it is 1 |
| wide_i | input | 1 | Width select: 1 = 20-bit words, 0 = 10-bit words |
| par_i | input | 20 | Parallel input word |
| line_oe | input | 1 | Enable for the line serial output |
| loop_oe | input | 1 | Enable for the loopback serial output |
| line_o | output | 1 | Line serial output |
| loop_o | output | 1 | Loopback serial output |
| wclk_o | output | 1 | Word-rate clock; parallel input is captured at its rising edge |

## Verification
Random words are streamed back to back in both width modes with `bit_en` held high.

- In 20-bit mode, this separates the ascending order across the two lanes from a reversed order or a swapped lane.
- In 10-bit mode, random data on the ignored low lane exposes any leak of that lane into the output.

A second pass thins `bit_en` to one edge in three. This shows that the word clock period and the bit sequence are counted in enabled bits rather than clock cycles. A third pass toggles the two output enables independently in the middle of words. This shows that a disabled output sits at idle while the stream underneath keeps its place.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;
  typedef enum logic {
    WIDTH_NARROW = 1'b0,
    WIDTH_WIDE   = 1'b1
  } width_e;
endpackage

// File: rtl/dws_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the active-low reset.
module dws_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/dws_bit_timer.sv
`timescale 1ns/1ps
// Bit position within the current word and the derived word clock.
module dws_bit_timer
  import dws_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int WORD_W = 20
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_en,
  input  width_e mode,
  output logic   wrap_o,
  output logic   wclk_o
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wclk_q, wclk_d;
  logic [CW-1:0] last_idx, half_idx;
  logic          at_last;

  always_comb begin
    last_idx = (mode == WIDTH_WIDE) ? CW'(WORD_W - 1) : CW'(CHAR_W - 1);
    half_idx = (mode == WIDTH_WIDE) ? CW'(WORD_W / 2) : CW'(CHAR_W / 2);
    at_last  = (cnt_q >= last_idx);
  end

  always_comb begin
    cnt_d  = cnt_q;
    wclk_d = wclk_q;
    if (bit_en) begin
      cnt_d  = at_last ? '0 : cnt_q + CW'(1);
      wclk_d = (cnt_d < half_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      wclk_q <= wclk_d;
    end
  end

  assign wrap_o = bit_en & at_last;
  assign wclk_o = wclk_q;
endmodule

// File: rtl/dws_word_latch.sv
`timescale 1ns/1ps
// Holds the captured word and arranges it in transmit order (index 0 first).
module dws_word_latch
  import dws_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  width_e            mode,
  input  logic [WORD_W-1:0] par_i,
  output logic [WORD_W-1:0] load_vec
);
  localparam int TOP_BASE = WORD_W - CHAR_W;

  logic [WORD_W-1:0] lat_q, lat_d;

  always_comb begin
    lat_d = lat_q;
    if (cap) lat_d = par_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  for (genvar gi = 0; gi < WORD_W; gi++) begin : g_order
    if (gi < CHAR_W) begin : g_first_char
      assign load_vec[gi] = (mode == WIDTH_WIDE) ? lat_q[gi] : lat_q[TOP_BASE + gi];
    end else begin : g_rest
      assign load_vec[gi] = (mode == WIDTH_WIDE) ? lat_q[gi] : 1'b0;
    end
  end
endmodule

// File: rtl/dws_shifter.sv
`timescale 1ns/1ps
// Output shift register, LSB on the line, with per-output gating.
module dws_shifter #(
  parameter int   WORD_W   = 20,
  parameter int   N_OUT    = 2,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              load,
  input  logic [WORD_W-1:0] load_vec,
  input  logic [N_OUT-1:0]  oe,
  output logic [N_OUT-1:0]  ser_o
);
  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (bit_en) begin
      if (load) sh_d = load_vec;
      else      sh_d = {1'b0, sh_q[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  for (genvar go = 0; go < N_OUT; go++) begin : g_out
    assign ser_o[go] = oe[go] ? sh_q[0] : IDLE_LVL;
  end
endmodule

// File: rtl/dws_serializer.sv
`timescale 1ns/1ps
module dws_serializer
  import dws_pkg::*;
#(
  parameter int   CHAR_W   = 10,
  parameter int   CHARS    = 2,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic                    wide_i,
  input  logic [CHAR_W*CHARS-1:0] par_i,
  input  logic                    line_oe,
  input  logic                    loop_oe,
  output logic                    line_o,
  output logic                    loop_o,
  output logic                    wclk_o
);
  localparam int WORD_W = CHAR_W * CHARS;
  localparam int N_OUT  = 2;

  logic              rst_n_int;
  width_e            mode;
  logic              wrap;
  logic [WORD_W-1:0] load_vec;
  logic [N_OUT-1:0]  oe_vec;
  logic [N_OUT-1:0]  ser_vec;

  assign mode   = width_e'(wide_i);
  assign oe_vec = {loop_oe, line_oe};

  dws_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dws_bit_timer #(.CHAR_W(CHAR_W), .WORD_W(WORD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .bit_en (bit_en),
    .mode   (mode),
    .wrap_o (wrap),
    .wclk_o (wclk_o)
  );

  dws_word_latch #(.CHAR_W(CHAR_W), .WORD_W(WORD_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cap      (wrap),
    .mode     (mode),
    .par_i    (par_i),
    .load_vec (load_vec)
  );

  dws_shifter #(.WORD_W(WORD_W), .N_OUT(N_OUT), .IDLE_LVL(IDLE_LVL)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .bit_en   (bit_en),
    .load     (wrap),
    .load_vec (load_vec),
    .oe       (oe_vec),
    .ser_o    (ser_vec)
  );

  assign line_o = ser_vec[0];
  assign loop_o = ser_vec[1];
endmodule

// File: rtl/dws_checker.sv
`timescale 1ns/1ps
module dws_checker #(
  parameter int   CHAR_W   = 10,
  parameter int   WORD_W   = 20,
  parameter logic IDLE_LVL = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              wide_i,
  input logic [WORD_W-1:0] par_i,
  input logic              line_oe,
  input logic              loop_oe,
  input logic              line_o,
  input logic              loop_o,
  input logic              wclk_o
);
  logic [7:0]        en_cnt;
  logic              primed;
  logic              wclk_q;
  logic              rise;
  logic [WORD_W-1:0] par_q;
  logic [WORD_W-1:0] prev_word;
  logic [7:0]        period_exp;

  assign rise       = wclk_o & ~wclk_q;
  assign period_exp = wide_i ? 8'(WORD_W) : 8'(CHAR_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_cnt    <= '0;
      primed    <= 1'b0;
      wclk_q    <= 1'b1;
      par_q     <= '0;
      prev_word <= '0;
    end else begin
      wclk_q <= wclk_o;
      par_q  <= par_i;
      if (rise) begin
        en_cnt    <= bit_en ? 8'd1 : 8'd0;
        primed    <= 1'b1;
        prev_word <= par_q;
      end else if (bit_en && en_cnt != 8'hFF) begin
        en_cnt <= en_cnt + 8'd1;
      end
    end
  end

  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && line_oe) |=> (!line_oe || $stable(line_o)));             // R6

  AST_WCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(wclk_o));                                         // R6

  AST_WORD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && primed) |-> (en_cnt == period_exp));                         // R7

  AST_FIRST_BIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && primed && line_oe) |->
      (line_o == (wide_i ? prev_word[0] : prev_word[WORD_W-CHAR_W])));    // R5

  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> (line_o == IDLE_LVL));                                   // R8

  AST_LOOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_oe |-> (loop_o == IDLE_LVL));                                   // R8
endmodule

bind dws_serializer dws_checker #(
  .CHAR_W   (CHAR_W),
  .WORD_W   (CHAR_W * CHARS),
  .IDLE_LVL (IDLE_LVL)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_en  (bit_en),
  .wide_i  (wide_i),
  .par_i   (par_i),
  .line_oe (line_oe),
  .loop_oe (loop_oe),
  .line_o  (line_o),
  .loop_o  (loop_o),
  .wclk_o  (wclk_o)
);

// File: tb/sim_dws_serializer.sv
`timescale 1ns/1ps
module sim_dws_serializer;
  localparam int CHAR_W = 10;
  localparam int WORD_W = 20;

  logic              clk;
  logic              rst_n;
  logic              bit_en;
  logic              wide_i;
  logic [WORD_W-1:0] par_i;
  logic              line_oe;
  logic              loop_oe;
  logic              line_o;
  logic              loop_o;
  logic              wclk_o;

  int    checks;
  int    errors;
  bit    done;
  bit    stall;
  bit    stream_on;
  bit    active;
  logic  en_seen;
  logic  wprev;
  int    bcount;
  int    per;
  int    phase;
  string tag;
  bit    exp_q[$];

  dws_serializer u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .wide_i  (wide_i),
    .par_i   (par_i),
    .line_oe (line_oe),
    .loop_oe (loop_oe),
    .line_o  (line_o),
    .loop_o  (loop_o),
    .wclk_o  (wclk_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bit enable pattern: steady, or one edge in three when stalling
  initial begin
    bit_en = 1'b1;
    phase  = 0;
    forever begin
      @(posedge clk);
      #1;
      phase++;
      bit_en = stall ? (phase % 3 == 0) : 1'b1;
    end
  end

  always @(posedge clk) en_seen <= bit_en;

  // monitor: pops expected bits from the scoreboard as the stream leaves
  always @(negedge clk) begin
    if (!stream_on) begin
      bcount = 0;
      active = 1'b0;
      per    = 0;
      wprev  = wclk_o;
    end else if (en_seen) begin
      per++;
      if (bcount >= 1 && per == (wide_i ? WORD_W : CHAR_W) / 2 - 1)
        chk(wclk_o == 1'b1, "R7", "word clock high in first half", wclk_o, 1);
      if (bcount >= 1 && per == (wide_i ? WORD_W : CHAR_W) / 2)
        chk(wclk_o == 1'b0, "R7", "word clock low in second half", wclk_o, 0);
      if (wclk_o && !wprev) begin
        if (bcount >= 1)
          chk(per == (wide_i ? WORD_W : CHAR_W), "R7", "word clock period", per,
              wide_i ? WORD_W : CHAR_W);
        per = 0;
        bcount++;
        if (bcount >= 2) active = 1'b1;
      end
      wprev = wclk_o;
      if (active && exp_q.size() > 0) begin
        bit b;
        b = exp_q.pop_front();
        chk(line_o == (line_oe ? b : 1'b0), line_oe ? tag : "R8", "line bit",
            line_o, line_oe ? b : 1'b0);
        chk(loop_o == (loop_oe ? b : 1'b0), loop_oe ? tag : "R8", "loop bit",
            loop_o, loop_oe ? b : 1'b0);
      end
    end
  end

  task automatic do_reset(input bit wide);
    stream_on = 1'b0;
    stall     = 1'b0;
    line_oe   = 1'b1;
    loop_oe   = 1'b1;
    par_i     = '0;
    rst_n     = 1'b0;
    wide_i    = wide;
    repeat (3) @(negedge clk);
    chk(wclk_o == 1'b1, "R1", "word clock in reset", wclk_o, 1);
    chk(line_o == 1'b0, "R1", "line output in reset", line_o, 0);
    chk(loop_o == 1'b0, "R1", "loop output in reset", loop_o, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic send_word(input logic [WORD_W-1:0] w);
    if (wide_i) begin
      for (int i = 0; i < WORD_W; i++) exp_q.push_back(w[i]);
    end else begin
      for (int i = 0; i < CHAR_W; i++) exp_q.push_back(w[WORD_W-CHAR_W+i]);
    end
    par_i = w;
    @(posedge wclk_o);
    @(negedge clk);
    #1;
  endtask

  task automatic run_stream(input bit wide, input bit stall_m, input bit oe_tog,
                            input int nwords, input string t);
    int guard;
    do_reset(wide);
    stall = stall_m;
    tag   = t;
    @(posedge wclk_o);
    @(negedge clk);
    #1;
    stream_on = 1'b1;
    for (int k = 0; k < nwords; k++) begin
      if (oe_tog) begin
        line_oe = (k % 3 != 1);
        loop_oe = (k % 4 != 2);
      end
      send_word(WORD_W'($urandom));
    end
    par_i = '0;
    guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    #1;
    chk(exp_q.size() == 0, "R5", "all queued bits emitted", exp_q.size(), 0);
    exp_q.delete();
    stream_on = 1'b0;
    line_oe   = 1'b1;
    loop_oe   = 1'b1;
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    stall     = 1'b0;
    stream_on = 1'b0;
    tag       = "R2";
    rst_n     = 1'b0;
    wide_i    = 1'b1;
    par_i     = '0;
    line_oe   = 1'b1;
    loop_oe   = 1'b1;

    run_stream(1'b1, 1'b0, 1'b0, 8, "R2 R5");
    run_stream(1'b0, 1'b0, 1'b0, 8, "R3 R4 R5");
    run_stream(1'b1, 1'b1, 1'b0, 6, "R6 R2");
    run_stream(1'b0, 1'b1, 1'b1, 8, "R6 R3");
    run_stream(1'b1, 1'b0, 1'b1, 8, "R2 R8");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule